// File: doc/BRIEF.md
# Serial Trigger Bus Link

This block is the transmit and receive logic of a four-line trigger distribution bus: a shared bit clock, a serial trigger line, a busy return line and a spare sync strobe. On the sending side, a 16-bit trigger word enters through a valid/ready stream port. The block sends it on the trigger line at one bit per bus clock. Each frame is 20 bit periods long, which is 200 ns at a 100 MHz bus clock. On the receiving side, the block watches the trigger line for a start bit and collects the 16 data bits that follow. It checks the stop bits and then presents the word with a one-cycle strobe.

The receiving board also drives the busy return line. A steady high level means the board is digitizing or reading out an event. An error is shown by the line inverting on every clock, which keeps it distinct from a steady level. The sync strobe is retimed through one register in each direction.

The stream input applies back-pressure by holding `tx_ready` low while a frame is being sent. A word transfers on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, `tx_valid` and `tx_word` are ignored, and the source must hold its word until the handshake completes. The received-word output has no back-pressure: the strobe appears once and the consumer must take it.

Top module: `trig_bus_link`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `trig_line_o`, `sync_line_o`, `busy_line_o`, `rx_valid`, `rx_frame_err` and `rx_sync_o` are 0 and `tx_ready` is 1.
- R2: After a word is accepted, `trig_line_o` carries a frame of 20 consecutive bits, one per clock. The frame is a start bit of 1, then the 16 data bits with bit 15 first, then three stop bits of 0. The first bit appears in the cycle after the accepting edge. Between frames the line is 0.
- R3: A word is taken on an edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is then 0 for the next 19 cycles and returns to 1 while the last stop bit is on the line. If `tx_valid` is still held, the next frame's start bit follows directly, so frames repeat every 20 cycles.
- R4: A `tx_valid` with a different word presented while `tx_ready` is 0 has no effect: the frame on the line keeps carrying the accepted word, and no extra frame follows.
- R5: The receiver samples the start bit on one edge and samples the next 19 bits on the 19 edges after it. After the edge that samples the third stop bit, `rx_valid` is 1 for exactly one cycle, with `rx_word` equal to the 16 data bits, first-received bit as bit 15.
- R6: If any of the three stop bits is sampled as 1, no `rx_valid` is given. Instead `rx_frame_err` is 1 for one cycle at the time `rx_valid` would have appeared, and `rx_word` keeps its previous value.
- R7: With `err_req` low, `busy_line_o` equals the value `busy_req` had one cycle earlier.
- R8: While `err_req` is 1, `busy_line_o` inverts on every clock, whatever the value of `busy_req`.
- R9: `sync_line_o` follows `sync_req` one cycle later, and `rx_sync_o` follows `rx_sync_line_i` one cycle later.
- R10: A trigger input held at 0 produces neither `rx_valid` nor `rx_frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_word | input | 16 | Trigger word to send |
| tx_valid | input | 1 | Word offered on `tx_word` |
| tx_ready | output | 1 | Sender idle, word can be taken |
| trig_line_o | output | 1 | Serial trigger line, driven |
| sync_req | input | 1 | Local sync strobe to send |
| sync_line_o | output | 1 | Sync line, driven |
| rx_trig_line_i | input | 1 | Serial trigger line, received |
| rx_word | output | 16 | Last correctly framed word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| rx_frame_err | output | 1 | One-cycle strobe for a bad stop bit |
| rx_sync_line_i | input | 1 | Sync line, received |
| rx_sync_o | output | 1 | Retimed received sync strobe |
| busy_req | input | 1 | Local digitization or readout in progress |
| err_req | input | 1 | Local error condition |
| busy_line_o | output | 1 | Busy return line, driven |

## Verification
Each result is due at a fixed cycle after its stimulus. The start bit appears one cycle after the accepting edge, and data bit k appears k cycles after the start bit. With the lines looped back, the receive strobe comes 20 cycles after the accepting edge. Busy, error toggling and both sync strobes appear one cycle after their inputs. The bench changes inputs and samples outputs one time unit after each rising edge, so every check reads the value produced by a known edge count. Transmit checks run on every bit of each frame. Receive checks use either a loopback or frames that the bench drives itself, including all eight stop-bit patterns.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  localparam int WORD_W = 16;
  localparam int STOP_N = 3;
  localparam int FRAME_LEN = 1 + WORD_W + STOP_N;
endpackage

// File: rtl/tbus_tx.sv
module tbus_tx #(
  parameter int WORD_W = tbus_pkg::WORD_W,
  parameter int STOP_N = tbus_pkg::STOP_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o
);
  localparam int SH_W  = WORD_W + STOP_N;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] left_q;
  logic             line_q;

  assign ready_o = (left_q == '0);
  assign line_o  = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      line_q <= 1'b0;
    end else if (valid_i && ready_o) begin
      line_q <= 1'b1;
      sh_q   <= {word_i, {STOP_N{1'b0}}};
      left_q <= CNT_W'(SH_W);
    end else if (left_q != '0) begin
      line_q <= sh_q[SH_W-1];
      sh_q   <= {sh_q[SH_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end else begin
      line_q <= 1'b0;
    end
  end

  a_r2_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> line_o);
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !ready_o);
  a_r2_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !line_o);
endmodule

// File: rtl/tbus_rx.sv
module tbus_rx #(
  parameter int WORD_W = tbus_pkg::WORD_W,
  parameter int STOP_N = tbus_pkg::STOP_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int SH_W  = WORD_W + STOP_N;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic              active_q;
  logic [CNT_W-1:0]  pos_q;
  logic [WORD_W-1:0] data_q;
  logic              bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      data_q   <= '0;
      bad_q    <= 1'b0;
      word_o   <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (!active_q) begin
        if (line_i) begin
          active_q <= 1'b1;
          pos_q    <= '0;
          bad_q    <= 1'b0;
        end
      end else begin
        pos_q <= pos_q + 1'b1;
        if (pos_q < CNT_W'(WORD_W)) begin
          data_q <= {data_q[WORD_W-2:0], line_i};
        end else begin
          bad_q <= bad_q | line_i;
        end
        if (pos_q == CNT_W'(SH_W - 1)) begin
          active_q <= 1'b0;
          if (bad_q || line_i) begin
            err_o <= 1'b1;
          end else begin
            valid_o <= 1'b1;
            word_o  <= data_q;
          end
        end
      end
    end
  end

  a_r6_valid_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));
  a_r5_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r6_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  a_r6_word_kept_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $stable(word_o));
endmodule

// File: rtl/tbus_busy_enc.sv
module tbus_busy_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic err_i,
  output logic line_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     line_o <= 1'b0;
    else if (err_i) line_o <= ~line_o;
    else            line_o <= busy_i;
  end

  a_r8_err_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> (line_o != $past(line_o)));
  a_r7_busy_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_i && busy_i) |=> line_o);
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_i && !busy_i) |=> !line_o);
endmodule

// File: rtl/tbus_sync_reg.sv
module tbus_sync_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= d_i;
  end

  a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    d_i |=> q_o);
endmodule

// File: rtl/trig_bus_link.sv
module trig_bus_link (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] tx_word,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        trig_line_o,
  input  logic        sync_req,
  output logic        sync_line_o,
  input  logic        rx_trig_line_i,
  output logic [15:0] rx_word,
  output logic        rx_valid,
  output logic        rx_frame_err,
  input  logic        rx_sync_line_i,
  output logic        rx_sync_o,
  input  logic        busy_req,
  input  logic        err_req,
  output logic        busy_line_o
);
  import tbus_pkg::*;

  tbus_tx #(.WORD_W(WORD_W), .STOP_N(STOP_N)) u_tx (
    .clk(clk), .rst_n(rst_n), .word_i(tx_word), .valid_i(tx_valid),
    .ready_o(tx_ready), .line_o(trig_line_o)
  );

  tbus_rx #(.WORD_W(WORD_W), .STOP_N(STOP_N)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_i(rx_trig_line_i), .word_o(rx_word),
    .valid_o(rx_valid), .err_o(rx_frame_err)
  );

  tbus_busy_enc u_busy (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_req), .err_i(err_req),
    .line_o(busy_line_o)
  );

  tbus_sync_reg u_sync_tx (
    .clk(clk), .rst_n(rst_n), .d_i(sync_req), .q_o(sync_line_o)
  );

  tbus_sync_reg u_sync_rx (
    .clk(clk), .rst_n(rst_n), .d_i(rx_sync_line_i), .q_o(rx_sync_o)
  );
endmodule

// File: tb/trig_bus_link_tb.sv
module trig_bus_link_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_word = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic        trig_line_o;
  logic        sync_req = 1'b0;
  logic        sync_line_o;
  logic        rx_trig_line_i;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic        rx_frame_err;
  logic        rx_sync_line_i = 1'b0;
  logic        rx_sync_o;
  logic        busy_req = 1'b0;
  logic        err_req = 1'b0;
  logic        busy_line_o;

  logic inj_en = 1'b0;
  logic inj_val = 1'b0;
  assign rx_trig_line_i = inj_en ? inj_val : trig_line_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] last_good = '0;

  always #2.5 clk = ~clk;

  trig_bus_link u_dut (
    .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .trig_line_o(trig_line_o), .sync_req(sync_req),
    .sync_line_o(sync_line_o), .rx_trig_line_i(rx_trig_line_i),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_sync_line_i(rx_sync_line_i), .rx_sync_o(rx_sync_o),
    .busy_req(busy_req), .err_req(err_req), .busy_line_o(busy_line_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // R2 R3 R4 R5: send one word, check every bit and the loopback strobe
  task automatic send_check(input logic [15:0] w, input bit noise);
    tx_word = w;
    tx_valid = 1'b1;
    step();
    chk(trig_line_o == 1'b1, "R2 start", trig_line_o, 1);
    chk(tx_ready == 1'b0, "R3 ready low", tx_ready, 0);
    if (noise) begin
      tx_word = ~w;
      tx_valid = 1'b1;
    end else begin
      tx_valid = 1'b0;
    end
    for (int k = 1; k <= 19; k++) begin
      logic expb;
      if (k == 18) tx_valid = 1'b0;
      step();
      expb = (k <= 16) ? w[16-k] : 1'b0;
      chk(trig_line_o == expb, noise ? "R4 bit" : "R2 bit", trig_line_o, expb);
      chk(tx_ready == (k == 19), "R3 ready", tx_ready, (k == 19));
      chk(!rx_valid && !rx_frame_err, "R5 early", rx_valid, 0);
    end
    step();
    chk(rx_valid == 1'b1, "R5 valid", rx_valid, 1);
    chk(rx_word == w, "R5 word", rx_word, w);
    chk(trig_line_o == 1'b0, "R4 no extra frame", trig_line_o, 0);
    last_good = w;
    step();
    chk(rx_valid == 1'b0, "R5 one cycle", rx_valid, 0);
  endtask

  // R6: drive a frame straight into the receiver with chosen stop bits
  task automatic inject(input logic [15:0] w, input logic [2:0] stops);
    inj_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      inj_val = (i == 0) ? 1'b1 : (i <= 16) ? w[16-i] : stops[19-i];
      step();
    end
    inj_val = 1'b0;
    if (stops == 3'b000) begin
      chk(rx_valid == 1'b1, "R6 good stops valid", rx_valid, 1);
      chk(rx_word == w, "R6 good stops word", rx_word, w);
      chk(rx_frame_err == 1'b0, "R6 no err", rx_frame_err, 0);
      last_good = w;
    end else begin
      chk(rx_valid == 1'b0, "R6 no valid", rx_valid, 0);
      chk(rx_frame_err == 1'b1, "R6 err", rx_frame_err, 1);
      chk(rx_word == last_good, "R6 word kept", rx_word, last_good);
    end
    step();
    chk(!rx_valid && !rx_frame_err, "R6 pulse ends", rx_frame_err, 0);
    inj_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step();
    step();
    chk(!trig_line_o && !sync_line_o && !busy_line_o, "R1 lines in reset",
        {trig_line_o, sync_line_o, busy_line_o}, 0);
    chk(!rx_valid && !rx_frame_err && !rx_sync_o, "R1 rx in reset",
        {rx_valid, rx_frame_err, rx_sync_o}, 0);
    chk(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
    rst_n = 1'b1;
    step();
    chk(!trig_line_o && tx_ready && !busy_line_o && !rx_valid, "R1 after reset",
        {trig_line_o, tx_ready, busy_line_o, rx_valid}, 4);

    // R10: idle line
    for (int i = 0; i < 25; i++) begin
      step();
      chk(!rx_valid && !rx_frame_err, "R10 idle", {rx_valid, rx_frame_err}, 0);
    end

    // R2 R5: walking ones, walking zeros, extremes, arithmetic sweep
    for (int i = 0; i < 16; i++) send_check(16'(1 << i), i[0]);
    for (int i = 0; i < 16; i++) send_check(~16'(1 << i), !i[0]);
    send_check(16'h0000, 1'b0);
    send_check(16'hFFFF, 1'b1);
    for (int i = 0; i < 8; i++) send_check(16'(i * 16'h2C5B + 16'h0013), 1'b1);

    // R3: back-to-back frames with valid held
    tx_word = 16'hBEEF;
    tx_valid = 1'b1;
    step();
    tx_word = 16'h4A71;
    for (int k = 1; k <= 20; k++) begin
      step();
      if (k == 20) begin
        chk(trig_line_o == 1'b1, "R3 back-to-back start", trig_line_o, 1);
        chk(rx_valid && rx_word == 16'hBEEF, "R3 first word", rx_word, 16'hBEEF);
        tx_valid = 1'b0;
      end
    end
    for (int k = 21; k <= 40; k++) begin
      step();
      if (k < 40) chk(!rx_valid, "R3 gap", rx_valid, 0);
    end
    chk(rx_valid && rx_word == 16'h4A71, "R3 second word", rx_word, 16'h4A71);
    last_good = 16'h4A71;
    step();

    // R6: every stop-bit pattern
    for (int p = 0; p < 8; p++) inject(16'h1234 + 16'(p * 16'h0101), 3'(p));

    // R7 R8: busy and error encoding
    busy_req = 1'b1;
    step();
    chk(busy_line_o == 1'b1, "R7 busy high", busy_line_o, 1);
    step();
    chk(busy_line_o == 1'b1, "R7 busy steady", busy_line_o, 1);
    busy_req = 1'b0;
    step();
    chk(busy_line_o == 1'b0, "R7 busy low", busy_line_o, 0);
    for (int b = 0; b < 2; b++) begin
      logic prev;
      busy_req = b[0];
      err_req = 1'b1;
      step();
      prev = busy_line_o;
      for (int i = 0; i < 6; i++) begin
        step();
        chk(busy_line_o == !prev, "R8 toggle", busy_line_o, !prev);
        prev = busy_line_o;
      end
      err_req = 1'b0;
      step();
      chk(busy_line_o == b[0], "R7 after error", busy_line_o, b[0]);
    end
    busy_req = 1'b0;

    // R9: sync strobes in both directions
    sync_req = 1'b1;
    rx_sync_line_i = 1'b0;
    step();
    chk(sync_line_o == 1'b1 && rx_sync_o == 1'b0, "R9 tx sync", sync_line_o, 1);
    sync_req = 1'b0;
    rx_sync_line_i = 1'b1;
    step();
    chk(sync_line_o == 1'b0 && rx_sync_o == 1'b1, "R9 rx sync", rx_sync_o, 1);
    rx_sync_line_i = 1'b0;
    step();
    chk(rx_sync_o == 1'b0, "R9 rx sync end", rx_sync_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule